// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block derives the serial clock of an I2C master from a fast system clock. A first stage divides the system clock by a 7-bit prescale value to make a reference tick, meant to sit near 10 MHz. Software picks the value as the system clock in MHz plus five, divided by ten. A second stage counts reference ticks to shape the SCL waveform. The low time and the high time are set on their own, each by one byte of a 16-bit divider word.

Each half-period count is 5,000,000 divided by the wanted bus rate in Hz. Equal bytes therefore give a 50% duty cycle. The usable range runs from 13 ticks (about 385 kHz) to 255 ticks (about 20 kHz). The block raises a fast-mode flag whenever the programmed rate is above 100 kHz. A global enable starts and stops the generator. While the enable is low, SCL is parked high and all counters are held at zero. Single-cycle strobes in the system clock domain mark each SCL edge, so a protocol engine can align data changes and sampling to them.

Top module: `scl_timing_gen`

## Requirements
- R1: While enabled, `ref_tick_o` is a one-cycle pulse that repeats every N system clock cycles, where N is `prescale_i` and a value of 0 acts as 1.
- R2: The SCL low phase lasts L×N system clock cycles, where L is the effective count taken from `divider_i[7:0]`.
- R3: The SCL high phase lasts H×N system clock cycles, where H is the effective count taken from `divider_i[15:8]`.
- R4: A half-period count below 13 is used as 13; counts from 13 to 255 are used unchanged.
- R5: `scl_fall_o` and `scl_rise_o` are single-cycle pulses. They are high exactly in the first cycle in which `scl_o` shows its new level, and they are never high together.
- R6: While `gen_en_i` is low, `scl_o` is 1 and `ref_tick_o`, `scl_rise_o` and `scl_fall_o` are 0. This takes effect one cycle after the enable drops. After re-enabling, the first falling strobe appears N+1 cycles after the first enabled edge. Reset gives the same parked state.
- R7: A new divider value is taken only at the falling edge that opens an SCL period. A write made during a period does not change that period's low or high time.
- R8: `fast_o` is 1 when L+H is below 100 (a rate above 100 kHz) and is 0 otherwise. It is evaluated on the divider value in use and updates at the opening falling edge.
- R9: `run_o` follows `gen_en_i` one cycle later and is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en_i | input | 1 | Global generator enable |
| prescale_i | input | 7 | System clock cycles per reference tick |
| divider_i | input | 16 | [15:8] high-phase ticks, [7:0] low-phase ticks |
| ref_tick_o | output | 1 | Reference tick pulse |
| scl_o | output | 1 | Generated serial clock level |
| scl_rise_o | output | 1 | Strobe in the first cycle of SCL high |
| scl_fall_o | output | 1 | Strobe in the first cycle of SCL low |
| run_o | output | 1 | Registered enable |
| fast_o | output | 1 | Fast-mode flag for the divider in use |

## Verification
The hardest case to reach from the ports is a divider write that lands in the middle of an SCL period. Only the boundary at the next falling edge shows whether the write was deferred. The stimulus first locks onto a falling strobe, changes the divider during the low phase, and then times the current low and high phases and the following pair. The two pairs must match the old value and then the new one. Disabling in the middle of a phase and the first-edge latency after re-enable are handled the same way: the bench aligns to a strobe and then counts cycles.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    localparam int DEF_PRE_W    = 7;
    localparam int DEF_CNT_W    = 8;
    localparam int DEF_MIN_HALF = 13;
    localparam int DEF_FAST_SUM = 100;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_strobe_t;

    // raise a half-period count to the legal floor
    function automatic int unsigned floor_count(input int unsigned c,
                                                input int unsigned lo_bound);
        return (c < lo_bound) ? lo_bound : c;
    endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PRE_W = scl_gen_pkg::DEF_PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PRE_W-1:0] ratio,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    assign limit = (ratio == '0) ? PRE_W'(1) : ratio;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= limit - PRE_W'(1)) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + PRE_W'(1);
            tick  <= 1'b0;
        end
    end

    // R6: no tick one cycle after the enable drops
    p_tick_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tick);
    // R1: a tick always comes out of a counter wrap
    p_tick_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        tick |-> cnt_q == '0);

endmodule

// File: rtl/scl_div_latch.sv
module scl_div_latch #(
    parameter int CNT_W    = scl_gen_pkg::DEF_CNT_W,
    parameter int MIN_HALF = scl_gen_pkg::DEF_MIN_HALF,
    parameter int FAST_SUM = scl_gen_pkg::DEF_FAST_SUM
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [2*CNT_W-1:0] div_raw,
    output logic [CNT_W-1:0]   lo_lim,
    output logic [CNT_W-1:0]   hi_lim,
    output logic               fast
);
    import scl_gen_pkg::*;

    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] lo_eff, hi_eff;
    logic [SUM_W-1:0] sum_eff;

    assign lo_eff  = CNT_W'(floor_count(int'(div_raw[CNT_W-1:0]), MIN_HALF));
    assign hi_eff  = CNT_W'(floor_count(int'(div_raw[2*CNT_W-1:CNT_W]), MIN_HALF));
    assign sum_eff = SUM_W'(lo_eff) + SUM_W'(hi_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_lim <= CNT_W'(MIN_HALF);
            hi_lim <= CNT_W'(MIN_HALF);
            fast   <= (2 * MIN_HALF) < FAST_SUM;
        end else if (load) begin
            lo_lim <= lo_eff;
            hi_lim <= hi_eff;
            fast   <= sum_eff < SUM_W'(FAST_SUM);
        end
    end

    // R4: limits in use never drop below the floor
    p_lim_floor_r4: assert property (@(posedge clk) disable iff (rst)
        lo_lim >= CNT_W'(MIN_HALF) && hi_lim >= CNT_W'(MIN_HALF));
    // R7: limits move only on a period boundary
    p_lim_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(lo_lim) && $stable(hi_lim) && $stable(fast));

endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
    parameter int CNT_W = scl_gen_pkg::DEF_CNT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     tick,
    input  logic [CNT_W-1:0]         lo_lim,
    input  logic [CNT_W-1:0]         hi_lim,
    output logic                     load,
    output logic                     scl,
    output scl_gen_pkg::edge_strobe_t strobe
);
    import scl_gen_pkg::*;

    phase_e           state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hi_done, lo_done;

    assign hi_done = (cnt_q >= hi_lim);
    assign lo_done = (cnt_q >= lo_lim);
    assign load    = en && tick &&
                     ((state_q == PH_IDLE) || (state_q == PH_HIGH && hi_done));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            scl     <= 1'b1;
            strobe  <= '0;
        end else begin
            strobe <= '0;
            if (tick) begin
                unique case (state_q)
                    PH_IDLE: begin
                        state_q     <= PH_LOW;
                        cnt_q       <= CNT_W'(1);
                        scl         <= 1'b0;
                        strobe.fall <= 1'b1;
                    end
                    PH_LOW: begin
                        if (lo_done) begin
                            state_q     <= PH_HIGH;
                            cnt_q       <= CNT_W'(1);
                            scl         <= 1'b1;
                            strobe.rise <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    PH_HIGH: begin
                        if (hi_done) begin
                            state_q     <= PH_LOW;
                            cnt_q       <= CNT_W'(1);
                            scl         <= 1'b0;
                            strobe.fall <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    default: begin
                        state_q <= PH_IDLE;
                        cnt_q   <= '0;
                        scl     <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R5: strobes mark real edges of the output
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(strobe.rise && strobe.fall));
    p_rise_edge_r5: assert property (@(posedge clk) disable iff (rst)
        strobe.rise |-> scl && !$past(scl));
    p_fall_edge_r5: assert property (@(posedge clk) disable iff (rst)
        strobe.fall |-> !scl && $past(scl));
    p_rise_once_r5: assert property (@(posedge clk) disable iff (rst)
        strobe.rise |=> !strobe.rise);
    // R6: parked high with no strobes after the enable drops
    p_park_high_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> scl && !strobe.rise && !strobe.fall);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
    parameter int PRE_W    = scl_gen_pkg::DEF_PRE_W,
    parameter int CNT_W    = scl_gen_pkg::DEF_CNT_W,
    parameter int MIN_HALF = scl_gen_pkg::DEF_MIN_HALF,
    parameter int FAST_SUM = scl_gen_pkg::DEF_FAST_SUM,
    localparam int DIV_W   = 2 * CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_en_i,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic [DIV_W-1:0] divider_i,
    output logic             ref_tick_o,
    output logic             scl_o,
    output logic             scl_rise_o,
    output logic             scl_fall_o,
    output logic             run_o,
    output logic             fast_o
);
    import scl_gen_pkg::*;

    logic             tick;
    logic             load;
    logic [CNT_W-1:0] lo_lim, hi_lim;
    edge_strobe_t     strobe;

    scl_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .en    (gen_en_i),
        .ratio (prescale_i),
        .tick  (tick)
    );

    scl_div_latch #(
        .CNT_W    (CNT_W),
        .MIN_HALF (MIN_HALF),
        .FAST_SUM (FAST_SUM)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .div_raw (divider_i),
        .lo_lim  (lo_lim),
        .hi_lim  (hi_lim),
        .fast    (fast_o)
    );

    scl_phase_ctr #(.CNT_W(CNT_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .en     (gen_en_i),
        .tick   (tick),
        .lo_lim (lo_lim),
        .hi_lim (hi_lim),
        .load   (load),
        .scl    (scl_o),
        .strobe (strobe)
    );

    always_ff @(posedge clk) begin
        if (rst) run_o <= 1'b0;
        else     run_o <= gen_en_i;
    end

    assign ref_tick_o = tick;
    assign scl_rise_o = strobe.rise;
    assign scl_fall_o = strobe.fall;

    // R9: registered enable
    p_run_follow_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> run_o == $past(gen_en_i));
    // R7: the divider latch reloads only with a falling strobe following
    p_load_at_fall_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> scl_fall_o);

endmodule

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gen_en_i = 1'b0;
    logic [6:0]  prescale_i = 7'd1;
    logic [15:0] divider_i = 16'h1414;
    logic        ref_tick_o, scl_o, scl_rise_o, scl_fall_o, run_o, fast_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scl_timing_gen dut_i (
        .clk(clk), .rst(rst), .gen_en_i(gen_en_i), .prescale_i(prescale_i),
        .divider_i(divider_i), .ref_tick_o(ref_tick_o), .scl_o(scl_o),
        .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o), .run_o(run_o),
        .fast_o(fast_o)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // 0 tick, 1 rise, 2 fall; counts negedges until the event is seen
    task automatic wait_ev(input int which, output int n);
        bit hit;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            hit = (which == 0) ? ref_tick_o : (which == 1) ? scl_rise_o : scl_fall_o;
        end while (!hit && n < 20000);
    endtask

    task automatic restart(input int pre, input logic [15:0] div);
        int n;
        @(negedge clk);
        gen_en_i   = 1'b0;
        prescale_i = 7'(pre);
        divider_i  = div;
        repeat (2) @(negedge clk);
        gen_en_i = 1'b1;
        wait_ev(2, n);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(scl_o == 1'b1, "R6 reset scl", int'(scl_o), 1);
        check(!ref_tick_o && !scl_rise_o && !scl_fall_o, "R6 reset strobes",
              int'(ref_tick_o | scl_rise_o | scl_fall_o), 0);
        check(run_o == 1'b0, "R9 reset run", int'(run_o), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_prescale();
        int n;
        restart(4, 16'h1414);
        wait_ev(0, n);
        wait_ev(0, n);
        check(n == 4, "R1 tick period N=4", n, 4);
        restart(0, 16'h1414);
        wait_ev(0, n);
        check(n == 1, "R1 tick period prescale 0", n, 1);
        restart(10, 16'h1414);
        wait_ev(0, n);
        wait_ev(0, n);
        check(n == 10, "R1 tick period N=10", n, 10);
    endtask

    task automatic t_phases();
        int n;
        restart(2, {8'd30, 8'd20});
        wait_ev(1, n);
        check(n == 40, "R2 low time 20x2", n, 40);
        check(scl_o == 1'b1, "R5 scl high with rise", int'(scl_o), 1);
        wait_ev(2, n);
        check(n == 60, "R3 high time 30x2", n, 60);
        check(scl_o == 1'b0, "R5 scl low with fall", int'(scl_o), 0);
        @(negedge clk);
        check(!scl_fall_o && !scl_rise_o, "R5 strobe one cycle",
              int'(scl_fall_o | scl_rise_o), 0);
        restart(1, {8'd255, 8'd255});
        wait_ev(1, n);
        check(n == 255, "R2 low time max 255", n, 255);
        wait_ev(2, n);
        check(n == 255, "R3 high time max 255", n, 255);
    endtask

    task automatic t_clamp();
        int n;
        restart(1, {8'd0, 8'd5});
        wait_ev(1, n);
        check(n == 13, "R4 low clamp 5->13", n, 13);
        wait_ev(2, n);
        check(n == 13, "R4 high clamp 0->13", n, 13);
        restart(3, {8'd13, 8'd14});
        wait_ev(1, n);
        check(n == 42, "R4 low 14 kept", n, 42);
        wait_ev(2, n);
        check(n == 39, "R4 high 13 kept", n, 39);
    endtask

    task automatic t_change();
        int n;
        restart(2, {8'd20, 8'd20});
        repeat (5) @(negedge clk);
        divider_i = {8'd30, 8'd30};
        wait_ev(1, n);
        check(n + 5 == 40, "R7 low keeps old", n + 5, 40);
        wait_ev(2, n);
        check(n == 40, "R7 high keeps old", n, 40);
        wait_ev(1, n);
        check(n == 60, "R7 new low next period", n, 60);
        wait_ev(2, n);
        check(n == 60, "R7 new high next period", n, 60);
    endtask

    task automatic t_fast();
        restart(1, {8'd13, 8'd13});
        check(fast_o == 1'b1, "R8 fast 13/13", int'(fast_o), 1);
        restart(1, {8'd50, 8'd50});
        check(fast_o == 1'b0, "R8 not fast 50/50", int'(fast_o), 0);
        restart(1, {8'd50, 8'd49});
        check(fast_o == 1'b1, "R8 fast 49/50", int'(fast_o), 1);
        restart(1, {8'd0, 8'd5});
        check(fast_o == 1'b1, "R8 fast clamped", int'(fast_o), 1);
    endtask

    task automatic t_enable();
        int n;
        int bad;
        restart(2, {8'd20, 8'd20});
        repeat (3) @(negedge clk);
        gen_en_i = 1'b0;
        @(negedge clk);
        check(scl_o == 1'b1, "R6 park high", int'(scl_o), 1);
        check(run_o == 1'b0, "R9 run drops", int'(run_o), 0);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ref_tick_o || scl_rise_o || scl_fall_o || !scl_o) bad++;
        end
        check(bad == 0, "R6 quiet while disabled", bad, 0);
        prescale_i = 7'd3;
        gen_en_i = 1'b1;
        @(negedge clk);
        check(run_o == 1'b1, "R9 run rises", int'(run_o), 1);
        n = 1;
        while (!scl_fall_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n == 4, "R6 first fall latency N+1", n, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_prescale();
        t_phases();
        t_clamp();
        t_change();
        t_fast();
        t_enable();
        done = 1'b1;
        summary();
    end

endmodule